// File: doc/BRIEF.md
# Indirect Register Access Sequencer

This block sits on the host side of a shared management bus. It turns one register access into the bus transactions that the target needs. A request gives a device number, a register number, a direction and, for a write, the data. The block answers with a one-cycle completion pulse, an error flag and the read data. It drives a frame-level master port with a valid/acknowledge handshake. Each handshake is one management-bus read or write of a 16-bit word at a 5-bit bus address and a 5-bit register number.

Three static configuration inputs pick how a request reaches the target:

- **Plain direct:** one bus transaction at the device number.
- **Offset direct:** one bus transaction at a base address plus the device number. This mode is for packages that hold two devices.
- **Windowed:** the target answers at the base address only, through a command register and a data register.

A windowed access checks the command register's busy bit before it issues the command, and checks it again afterwards. Each check polls at most a bounded number of times, with a programmable idle gap between polls. A bus error ends the sequence at once, and so does a poll that runs out of tries. Either one is reported as an error.

Top module: `regacc_seq`

## Requirements
- R1: With `cfg_dual` high, a request makes exactly one bus transaction. Its address is `cfg_base + req_dev` (modulo 32), its register number is `req_reg`, and its direction and write data are those of the request.
- R2: With `cfg_dual` low and `cfg_base` zero, a request makes exactly one bus transaction at address `req_dev` and register `req_reg`.
- R3: With `cfg_dual` low, `cfg_base` non-zero and `cfg_multi` low, the request completes with an error on the cycle after acceptance, and no bus transaction is made.
- R4: A windowed read makes these transactions at address `cfg_base`, in order:
  - poll reads of register 0 until bit 15 reads 0;
  - a command write to register 0;
  - poll reads of register 0 until bit 15 reads 0;
  - one read of register 1. Its 16-bit value is returned.
- R5: A windowed write makes these transactions at address `cfg_base`, in order:
  - poll reads of register 0 until bit 15 reads 0;
  - a write of the request data to register 1;
  - a command write to register 0;
  - poll reads of register 0 until bit 15 reads 0.
- R6: The command word has these fields:
  - bit 15 is 1 (busy);
  - bit 12 is 1 (clause-22 flag);
  - bits 11:10 are 2'b10 for a read and 2'b01 for a write;
  - bits 9:5 hold the device number;
  - bits 4:0 hold the register number;
  - all other bits are 0.
- R7: One busy wait makes at most `POLL_MAX` poll reads. If all of them return bit 15 set, the request completes with an error, and no further transaction follows.
- R8: Between two poll reads of the same wait, `bus_valid` stays low for at least `DELAY_CYC` cycles.
- R9: A transaction acknowledged with `bus_err` high ends the request with an error, and no further transaction follows.
- R10: A poll result is judged only by bit 15. The other bits of the status word do not change the sequence.
- R11: A request is accepted only while `busy` is low. `req_valid` while busy is ignored. `busy` is high from acceptance to completion, and `bus_valid` is never high while `busy` is low.
- R12: `rsp_done` is high for exactly one cycle per accepted request, together with `rsp_err`. `rsp_rdata` carries the read value of a successful read and is 0 for writes and errors.
- R13: While `bus_valid` is high and `bus_ack` is low, `bus_valid`, `bus_write`, `bus_addr`, `bus_reg` and `bus_wdata` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dual | input | 1 | Offset direct addressing selected |
| cfg_multi | input | 1 | Target supports the windowed scheme |
| cfg_base | input | ADDR_W | Base bus address |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | ADDR_W | Device number |
| req_reg | input | ADDR_W | Register number |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Request in progress |
| rsp_done | output | 1 | Completion pulse |
| rsp_err | output | 1 | Error flag, valid with `rsp_done` |
| rsp_rdata | output | DATA_W | Read data, valid with `rsp_done` |
| bus_valid | output | 1 | Bus transaction request |
| bus_write | output | 1 | Bus transaction direction |
| bus_addr | output | ADDR_W | Bus address |
| bus_reg | output | ADDR_W | Bus register number |
| bus_wdata | output | DATA_W | Bus write data |
| bus_ack | input | 1 | Transaction complete |
| bus_err | input | 1 | Transaction failed, valid with `bus_ack` |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |

## Verification
Both direct modes are driven with reads and writes to several device and register numbers. This shows whether the address is the device number alone or offset by the base. The invalid configuration is driven as well, and it must leave the bus untouched.

Windowed reads and writes are driven with status responders that hold the busy bit for zero, some or too many polls, separately before and after the command. This tells a correct step order and poll bound apart from early or missing polls. The responder returns the status word with every other bit set when idle and only bit 15 set when busy, which exposes any decision made on the wrong bit.

Bus errors are injected mid-sequence. Acknowledges are delayed to stress request hold. A second request arrives while the block is busy and must be ignored.

// File: rtl/regacc_pkg.sv
package regacc_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT, MODE_OFFSET, MODE_INDIRECT, MODE_BAD
  } mode_e;

  typedef enum logic [2:0] {
    STEP_DIRECT, STEP_POLL_A, STEP_CMD, STEP_POLL_B, STEP_DATA_RD, STEP_DATA_WR
  } step_e;

  typedef enum logic [1:0] {PH_IDLE, PH_BUS, PH_GAP} phase_e;

  // Command word layout and window offsets
  localparam int BUSY_BIT = 15;
  localparam int C22_BIT  = 12;
  localparam int OP_LSB   = 10;
  localparam int DEV_LSB  = 5;
  localparam int WIN_CMD  = 0;
  localparam int WIN_DATA = 1;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  function automatic step_e step_after(step_e s, logic wr);
    case (s)
      STEP_POLL_A:  return wr ? STEP_DATA_WR : STEP_CMD;
      STEP_DATA_WR: return STEP_CMD;
      STEP_CMD:     return STEP_POLL_B;
      STEP_POLL_B:  return STEP_DATA_RD;
      default:      return STEP_DIRECT;
    endcase
  endfunction

  function automatic logic step_final(step_e s, logic wr);
    case (s)
      STEP_DIRECT:  return 1'b1;
      STEP_POLL_B:  return wr;
      STEP_DATA_RD: return 1'b1;
      default:      return 1'b0;
    endcase
  endfunction

  function automatic logic step_is_poll(step_e s);
    return (s == STEP_POLL_A) || (s == STEP_POLL_B);
  endfunction

  function automatic logic step_gives_data(step_e s, logic wr);
    return ((s == STEP_DIRECT) && !wr) || (s == STEP_DATA_RD);
  endfunction

endpackage

// File: rtl/regacc_step_dec.sv
module regacc_step_dec
  import regacc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  step_e               step,
  input  mode_e               mode,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   base,
  input  logic [ADDR_W-1:0]   dev,
  input  logic [ADDR_W-1:0]   rnum,
  input  logic [DATA_W-1:0]   wdata,
  output logic                o_write,
  output logic [ADDR_W-1:0]   o_addr,
  output logic [ADDR_W-1:0]   o_reg,
  output logic [DATA_W-1:0]   o_data
);
  logic [DATA_W-1:0] cmd;

  always_comb begin
    cmd                    = '0;
    cmd[BUSY_BIT]          = 1'b1;
    cmd[C22_BIT]           = 1'b1;
    cmd[OP_LSB +: 2]       = wr ? OP_WRITE : OP_READ;
    cmd[DEV_LSB +: ADDR_W] = dev;
    cmd[0 +: ADDR_W]       = rnum;
  end

  always_comb begin
    o_write = 1'b0;
    o_addr  = base;
    o_reg   = ADDR_W'(WIN_CMD);
    o_data  = wdata;
    case (step)
      STEP_DIRECT: begin
        o_write = wr;
        o_addr  = (mode == MODE_OFFSET) ? base + dev : dev;
        o_reg   = rnum;
      end
      STEP_CMD: begin
        o_write = 1'b1;
        o_data  = cmd;
      end
      STEP_DATA_RD: o_reg = ADDR_W'(WIN_DATA);
      STEP_DATA_WR: begin
        o_write = 1'b1;
        o_reg   = ADDR_W'(WIN_DATA);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/regacc_gap_timer.sv
module regacc_gap_timer #(
  parameter int CYCLES = 4,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (start)        cnt <= CW'(CYCLES);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == CW'(1));
endmodule

// File: rtl/regacc_seq.sv
module regacc_seq
  import regacc_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int POLL_MAX  = 16,
  parameter int DELAY_CYC = 187500,
  localparam int PC_W = $clog2(POLL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_dual,
  input  logic              cfg_multi,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_dev,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [ADDR_W-1:0] bus_reg,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [DATA_W-1:0] bus_rdata
);
  phase_e            phase_q;
  step_e             step_q;
  mode_e             mode_q, mode_sel;
  logic              wr_q;
  logic [ADDR_W-1:0] base_q, dev_q, reg_q;
  logic [DATA_W-1:0] wdata_q;
  logic [PC_W-1:0]   poll_cnt;
  logic              gap_start, gap_done, poll_busy, poll_last;

  always_comb begin
    if (cfg_dual)            mode_sel = MODE_OFFSET;
    else if (cfg_base == '0) mode_sel = MODE_DIRECT;
    else if (cfg_multi)      mode_sel = MODE_INDIRECT;
    else                     mode_sel = MODE_BAD;
  end

  regacc_step_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .step(step_q), .mode(mode_q), .wr(wr_q), .base(base_q), .dev(dev_q),
    .rnum(reg_q), .wdata(wdata_q), .o_write(bus_write), .o_addr(bus_addr),
    .o_reg(bus_reg), .o_data(bus_wdata)
  );

  assign poll_busy = bus_rdata[BUSY_BIT];
  assign poll_last = (poll_cnt == PC_W'(POLL_MAX - 1));
  assign gap_start = (phase_q == PH_BUS) && bus_ack && !bus_err &&
                     step_is_poll(step_q) && poll_busy && !poll_last;

  regacc_gap_timer #(.CYCLES(DELAY_CYC)) u_gap (
    .clk(clk), .rst(rst), .start(gap_start), .expired(gap_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      step_q    <= STEP_DIRECT;
      mode_q    <= MODE_DIRECT;
      wr_q      <= 1'b0;
      base_q    <= '0;
      dev_q     <= '0;
      reg_q     <= '0;
      wdata_q   <= '0;
      poll_cnt  <= '0;
      busy      <= 1'b0;
      bus_valid <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      case (phase_q)
        PH_IDLE: if (req_valid) begin
          mode_q   <= mode_sel;
          wr_q     <= req_write;
          base_q   <= cfg_base;
          dev_q    <= req_dev;
          reg_q    <= req_reg;
          wdata_q  <= req_wdata;
          poll_cnt <= '0;
          step_q   <= (mode_sel == MODE_INDIRECT) ? STEP_POLL_A : STEP_DIRECT;
          if (mode_sel == MODE_BAD) begin
            rsp_done  <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_rdata <= '0;
          end else begin
            busy      <= 1'b1;
            bus_valid <= 1'b1;
            phase_q   <= PH_BUS;
          end
        end
        PH_BUS: if (bus_ack) begin
          bus_valid <= 1'b0;
          if (bus_err || (step_is_poll(step_q) && poll_busy && poll_last)) begin
            phase_q   <= PH_IDLE;
            busy      <= 1'b0;
            rsp_done  <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_rdata <= '0;
          end else if (step_is_poll(step_q) && poll_busy) begin
            poll_cnt <= poll_cnt + 1'b1;
            phase_q  <= PH_GAP;
          end else if (step_final(step_q, wr_q)) begin
            phase_q   <= PH_IDLE;
            busy      <= 1'b0;
            rsp_done  <= 1'b1;
            rsp_rdata <= step_gives_data(step_q, wr_q) ? bus_rdata : '0;
          end else begin
            step_q    <= step_after(step_q, wr_q);
            poll_cnt  <= '0;
            bus_valid <= 1'b1;
          end
        end
        PH_GAP: if (gap_done) begin
          phase_q   <= PH_BUS;
          bus_valid <= 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regacc_chk.sv
module regacc_chk
  import regacc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              rsp_done,
  input logic              rsp_err,
  input logic              bus_valid,
  input logic              bus_ack,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [ADDR_W-1:0] bus_reg,
  input logic [DATA_W-1:0] bus_wdata,
  input mode_e             mode_q
);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R12
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_done);

  // R12
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> rsp_done);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_valid);

  // R13
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_write) &&
      $stable(bus_addr) && $stable(bus_reg) && $stable(bus_wdata)));

  // R6
  cmd_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && mode_q == MODE_INDIRECT && bus_reg == '0) |->
      (bus_wdata[BUSY_BIT] && bus_wdata[C22_BIT] &&
       (bus_wdata[OP_LSB +: 2] == OP_READ || bus_wdata[OP_LSB +: 2] == OP_WRITE)));
endmodule

bind regacc_seq regacc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .rsp_done(rsp_done), .rsp_err(rsp_err),
  .bus_valid(bus_valid), .bus_ack(bus_ack), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_reg(bus_reg), .bus_wdata(bus_wdata), .mode_q(mode_q)
);

// File: tb/sim_regacc_seq.sv
`timescale 1ns/1ps
module sim_regacc_seq;
  localparam int P = 4;
  localparam int D = 4;

  logic clk = 0, rst = 1;
  logic cfg_dual = 0, cfg_multi = 0;
  logic [4:0] cfg_base = 0;
  logic req_valid = 0, req_write = 0;
  logic [4:0] req_dev = 0, req_reg = 0;
  logic [15:0] req_wdata = 0;
  logic busy, rsp_done, rsp_err, bus_valid, bus_write;
  logic [15:0] rsp_rdata, bus_wdata;
  logic [4:0] bus_addr, bus_reg;
  logic bus_ack = 0, bus_err = 0;
  logic [15:0] bus_rdata = 0;

  always #4 clk = ~clk;

  regacc_seq #(.POLL_MAX(P), .DELAY_CYC(D)) u0 (
    .clk(clk), .rst(rst), .cfg_dual(cfg_dual), .cfg_multi(cfg_multi),
    .cfg_base(cfg_base), .req_valid(req_valid), .req_write(req_write),
    .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata), .busy(busy),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_reg(bus_reg), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  typedef struct {
    bit w; logic [4:0] a; logic [4:0] r; logic [15:0] d; string t;
  } txn_t;

  txn_t exp_q[$];
  int n_chk = 0, n_err = 0, done_cnt = 0;
  int busy1 = 0, busy2 = 0, err_at = -1, ack_lag = 0;
  bit ind_mode = 0, exp_err = 0;
  logic [15:0] exp_rdata = 0, data_word = 0;
  string cur_tag = "R12";

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  // Responder: acks after ack_lag extra cycles, models the command window
  initial begin
    int nidx = 0, p1 = 0, p2 = 0, lagc = 0;
    bit cmd_seen = 0;
    forever begin
      @(posedge clk);
      if (rst || !busy) begin
        bus_ack <= 0; bus_err <= 0; nidx = 0; p1 = 0; p2 = 0; lagc = 0; cmd_seen = 0;
      end else if (bus_valid && !bus_ack && lagc < ack_lag) begin
        lagc++;
      end else if (bus_valid && !bus_ack) begin
        lagc = 0;
        bus_ack <= 1;
        bus_err <= (nidx == err_at);
        nidx++;
        if (bus_write) begin
          if (ind_mode && bus_reg == 0) cmd_seen = 1;
          bus_rdata <= 16'h0;
        end else if (ind_mode && bus_reg == 0) begin
          if (!cmd_seen) begin bus_rdata <= (p1 < busy1) ? 16'h8000 : 16'h7FFF; p1++; end
          else begin bus_rdata <= (p2 < busy2) ? 16'h8000 : 16'h7FFF; p2++; end
        end else if (ind_mode) bus_rdata <= data_word;
        else bus_rdata <= {6'b0, bus_addr, bus_reg};
      end else begin
        bus_ack <= 0; bus_err <= 0;
      end
    end
  end

  // Monitor / scoreboard
  initial begin
    bit prev_valid = 0, prev_hold = 0, busy_poll = 0, prev_done = 0;
    int gap = 0;
    logic [37:0] held = 0;
    txn_t e;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (prev_hold && bus_valid)
          chk({bus_write, bus_addr, bus_reg, bus_wdata, 11'b0} == held, "R13", "request changed before ack",
              32'({bus_write, bus_addr, bus_reg}), 32'(held[37:27]));
        prev_hold = bus_valid && !bus_ack;
        held = {bus_write, bus_addr, bus_reg, bus_wdata, 11'b0};
        if (bus_valid && !prev_valid) begin
          if (busy_poll) chk(gap >= D, "R8", "idle gap between polls", gap, D);
          busy_poll = 0;
          gap = 0;
        end else if (!bus_valid && busy) gap++;
        prev_valid = bus_valid;
        if (bus_valid && bus_ack) begin
          if (exp_q.size() == 0) begin
            chk(0, cur_tag, "unexpected transaction", 32'({bus_write, bus_addr, bus_reg}), 0);
          end else begin
            e = exp_q.pop_front();
            chk(bus_write == e.w && bus_addr == e.a && bus_reg == e.r &&
                (!e.w || bus_wdata == e.d), e.t, "transaction {w,addr,reg,wdata}",
                {bus_write, bus_addr, bus_reg, bus_wdata}, {e.w, e.a, e.r, e.d});
          end
          busy_poll = ind_mode && !bus_write && bus_reg == 0 && bus_rdata[15] && !bus_err;
        end
        if (rsp_done) begin
          done_cnt++;
          busy_poll = 0;
          chk(!prev_done, "R12", "done longer than one cycle", 1, 0);
          chk(rsp_err == exp_err, cur_tag, "error flag", rsp_err, exp_err);
          chk(rsp_rdata == exp_rdata, cur_tag, "read data", rsp_rdata, exp_rdata);
          chk(exp_q.size() == 0, cur_tag, "missing transactions", exp_q.size(), 0);
        end
        prev_done = rsp_done;
      end
    end
  end

  task automatic add(bit w, logic [4:0] a, logic [4:0] r, logic [15:0] d, string t);
    txn_t x;
    x.w = w; x.a = a; x.r = r; x.d = d; x.t = t;
    exp_q.push_back(x);
  endtask

  task automatic expect_req(string tag, bit w, logic [4:0] dev, logic [4:0] rg, logic [15:0] wd);
    logic [4:0] a;
    logic [15:0] cmdw;
    int n1, n2;
    exp_q.delete();
    cur_tag = tag; exp_err = 0; exp_rdata = 0; ind_mode = 0;
    if (cfg_dual || cfg_base == 0) begin
      a = cfg_dual ? cfg_base + dev : dev;
      add(w, a, rg, wd, tag);
      if (!w) exp_rdata = {6'b0, a, rg};
    end else if (cfg_multi) begin
      ind_mode = 1;
      cmdw = 16'h9000 | (w ? 16'h0400 : 16'h0800) | {6'b0, dev, rg};
      n1 = (busy1 + 1 > P) ? P : busy1 + 1;
      n2 = (busy2 + 1 > P) ? P : busy2 + 1;
      repeat (n1) add(0, cfg_base, 0, 0, tag);
      if (busy1 >= P) exp_err = 1;
      else begin
        if (w) add(1, cfg_base, 1, wd, tag);
        add(1, cfg_base, 0, cmdw, "R6");
        repeat (n2) add(0, cfg_base, 0, 0, tag);
        if (busy2 >= P) exp_err = 1;
        else if (!w) begin add(0, cfg_base, 1, 0, tag); exp_rdata = data_word; end
      end
    end else exp_err = 1;
    if (err_at >= 0 && err_at < exp_q.size()) begin
      while (exp_q.size() > err_at + 1) void'(exp_q.pop_back());
      exp_err = 1;
    end
    if (exp_err) exp_rdata = 0;
  endtask

  task automatic pulse(bit w, logic [4:0] dev, logic [4:0] rg, logic [15:0] wd);
    @(negedge clk);
    req_valid = 1; req_write = w; req_dev = dev; req_reg = rg; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic run(string tag, bit w, logic [4:0] dev, logic [4:0] rg, logic [15:0] wd);
    int s = done_cnt;
    expect_req(tag, w, dev, rg, wd);
    pulse(w, dev, rg, wd);
    while (done_cnt == s) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R12 watchdog: actual no completion expected completion");
    finish_up();
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !rsp_done && !bus_valid, "R11", "idle after reset",
        {busy, rsp_done, bus_valid}, 0);

    cfg_dual = 0; cfg_multi = 1; cfg_base = 0;
    run("R2", 0, 5'd3, 5'd7, 0);
    run("R2", 1, 5'd30, 5'd1, 16'hC0DE);

    cfg_dual = 1; cfg_base = 5'd16;
    run("R1", 1, 5'd5, 5'd9, 16'h1357);
    cfg_base = 5'd30;
    run("R1", 0, 5'd4, 5'd2, 0);

    cfg_dual = 0; cfg_multi = 0; cfg_base = 5'd8;
    run("R3", 0, 5'd1, 5'd1, 0);

    cfg_multi = 1; cfg_base = 5'd8;
    busy1 = 2; busy2 = 1; data_word = 16'h1234;
    run("R4", 0, 5'd6, 5'd3, 0);
    busy1 = 1; busy2 = 0; data_word = 16'h8001;
    run("R10", 0, 5'd31, 5'd31, 0);
    busy1 = 0; busy2 = 3;
    run("R5", 1, 5'd2, 5'd17, 16'hBEEF);

    busy1 = 4; busy2 = 0;
    run("R7", 0, 5'd1, 5'd4, 0);
    busy1 = 0; busy2 = 5;
    run("R7", 1, 5'd1, 5'd4, 16'h00FF);
    busy1 = 3; busy2 = 3;
    run("R8", 0, 5'd9, 5'd10, 0);

    busy1 = 1; busy2 = 0; err_at = 2;
    run("R9", 1, 5'd7, 5'd5, 16'h4242);
    cfg_base = 0; err_at = 0;
    run("R9", 0, 5'd7, 5'd5, 0);
    err_at = -1;

    ack_lag = 3; cfg_base = 5'd8; busy1 = 1; busy2 = 1; data_word = 16'h0F0F;
    run("R13", 0, 5'd12, 5'd6, 0);
    ack_lag = 0;

    busy1 = 3; busy2 = 0; data_word = 16'hA55A;
    s = done_cnt;
    expect_req("R11", 0, 5'd4, 5'd4, 0);
    pulse(0, 5'd4, 5'd4, 0);
    repeat (2) @(negedge clk);
    pulse(1, 5'd20, 5'd20, 16'hFFFF);
    while (done_cnt == s) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(done_cnt == s + 1 && !bus_valid, "R11", "request while busy ignored",
        done_cnt - s, 1);

    finish_up();
  end
endmodule